// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator

This block drives two independent pulse-width modulated output pins. Each pin is governed by a single 32-bit control word reached over a plain memory-mapped write/read bus, one word per channel on consecutive word addresses. A control word carries a run flag, an 8-bit clock divider setting and an 8-bit level code. While a channel runs, its divider turns the core clock into a slower tick, and an 8-bit phase counter advances once per tick. A full output period is therefore 256 ticks long.

The level code is inverted: larger codes give shorter high pulses, and code 0 keeps the pin low. Divider and level settings written while a channel runs are held back until the current period ends, so a change never produces a clipped pulse. Software programs a channel by writing its word with the run flag set. It stops the channel by writing the word again with the flag cleared.

Top module: `twin_pwm`

## Requirements
- R1: After reset, both control words read as 0 and both outputs are low.
- R2: A write to byte offset 0 (channel 0) or 4 (channel 1) stores all 32 data bits. A later read of that offset returns the stored word unchanged, including bits the channel does not use.
- R3: A write to any other offset (8, 12, or any offset with address bits 1:0 not zero) changes no control word. A read of such an offset returns 0.
- R4: Bit 31 is the run flag. From the first clock edge after a write that clears it, the channel's output stays low.
- R5: For a running channel, bits 15:8 (divider D, 1 to 255) set one tick to D clock cycles, and the period to 256·D cycles. Bits 7:0 (level code L, 1 to 255) make the output high for (256 − L)·D cycles in each period.
- R6: A divider value of 0 acts as D = 256, giving a period of 65536 cycles.
- R7: A level code of 0 keeps a running channel's output low for the whole period.
- R8: Level code 1 gives 255 high ticks per period, and level code 255 gives exactly one high tick.
- R9: When a write sets the run flag of a stopped channel, the channel restarts at phase 0 with a cleared divider. Its output is high in the first cycle after the following clock edge whenever the level code is nonzero.
- R10: Divider and level values written while the channel runs take effect at the next period boundary. The period in progress completes with the old values.
- R11: The two channels run independently, each with its own settings, and do not disturb each other's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 2 | Modulated output, one bit per channel |

## Verification
The assertions check, on every cycle, the following bus and state relationships:
- a decoded write lands in its word (R2), and an undecoded write changes nothing (R3);
- clearing the run flag silences the pin (R4);
- a code-0 channel stays low (R7);
- a start always begins at phase 0 with a cleared divider (R9);
- the shadowed level only changes at a period boundary or while stopped (R10).

Only the bench's scenarios can show that the high time and period have the expected lengths for specific divider and level values (R5, R6, R8). The same holds for the slowest divider setting and for a mid-period update producing one full old-value period followed by a full new-value period.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;

   // bytes per control word; channel n sits at byte offset n*WORD_BYTES
   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned WORD_SHIFT = $clog2(WORD_BYTES);

   // per-channel run state
   typedef enum logic {
      CH_IDLE = 1'b0,
      CH_RUN  = 1'b1
   } ch_state_e;

endpackage

// File: rtl/twin_pwm_regs.sv
module twin_pwm_regs
   import twin_pwm_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_wr,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [DATA_W-1:0]             bus_rdata,
   output logic [NCH-1:0][DATA_W-1:0]    ctl_q
);

   localparam int IDX_W = ADDR_W - WORD_SHIFT;

   logic [IDX_W-1:0] word_idx;
   logic             aligned;
   logic [NCH-1:0]   sel;

   assign word_idx = bus_addr[ADDR_W-1:WORD_SHIFT];
   assign aligned  = (bus_addr[WORD_SHIFT-1:0] == '0);

   // one-hot decode of the addressed channel word
   for (genvar c = 0; c < NCH; c++) begin : g_dec
      assign sel[c] = aligned && (int'(word_idx) == c);
   end

   // storage: every bit of each word is kept for read-back
   for (genvar c = 0; c < NCH; c++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_q[c] <= '0;
         end else if (bus_wr && sel[c]) begin
            ctl_q[c] <= bus_wdata;
         end
      end
   end

   // read mux, zero for undecoded offsets
   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NCH; c++) begin
         if (sel[c]) begin
            bus_rdata = ctl_q[c];
         end
      end
   end

endmodule

// File: rtl/twin_pwm_presc.sv
module twin_pwm_presc #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic [CW-1:0] code_i,
   output logic          tick_o,
   output logic [CW-1:0] cnt_o
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_cnt;

   // code 0 stands for the full 2**CW division
   assign last_cnt = (code_i == '0) ? '1 : (code_i - 1'b1);
   assign tick_o   = run_i && (cnt_q == last_cnt);
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/twin_pwm_chan.sv
module twin_pwm_chan
   import twin_pwm_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic [CW-1:0] reload_i,
   input  logic [CW-1:0] duty_i,
   output logic          pwm_o,
   output logic [CW-1:0] phase_o,
   output logic [CW-1:0] presc_o,
   output logic          run_o,
   output logic [CW-1:0] duty_sh_o
);

   ch_state_e     st_q;
   logic [CW-1:0] ph_q;
   logic [CW-1:0] rl_sh_q;
   logic [CW-1:0] dt_sh_q;
   logic          tick;
   logic          running;
   logic [CW:0]   ph_sum;

   assign running = (st_q == CH_RUN);

   twin_pwm_presc #(.CW(CW)) presc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (running),
      .code_i (rl_sh_q),
      .tick_o (tick),
      .cnt_o  (presc_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= CH_IDLE;
         ph_q    <= '0;
         rl_sh_q <= '0;
         dt_sh_q <= '0;
      end else begin
         st_q <= en_i ? CH_RUN : CH_IDLE;
         if (!running) begin
            // stopped: shadows follow the register, phase parked at 0
            ph_q    <= '0;
            rl_sh_q <= reload_i;
            dt_sh_q <= duty_i;
         end else if (tick) begin
            ph_q <= ph_q + 1'b1;
            if (&ph_q) begin
               // period boundary: adopt pending settings
               rl_sh_q <= reload_i;
               dt_sh_q <= duty_i;
            end
         end
      end
   end

   // high while phase + code stays below 2**CW, i.e. (2**CW - code) ticks
   assign ph_sum = {1'b0, ph_q} + {1'b0, dt_sh_q};
   assign pwm_o  = en_i && running && (dt_sh_q != '0) && !ph_sum[CW];

   assign phase_o   = ph_q;
   assign run_o     = running;
   assign duty_sh_o = dt_sh_q;

endmodule

// File: rtl/twin_pwm.sv
module twin_pwm
   import twin_pwm_pkg::*;
#(
   parameter int NCH        = 2,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int CW         = 8,
   parameter int EN_BIT     = 31,
   parameter int RELOAD_LSB = 8,
   parameter int DUTY_LSB   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NCH-1:0]    pwm_out
);

   localparam int MIN_ADDR_W = WORD_SHIFT + ((NCH > 1) ? $clog2(NCH) : 1);

   // elaboration-time parameter checks
   if (NCH < 1) begin : g_bad_nch
      $error("twin_pwm: NCH must be at least 1");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("twin_pwm: ADDR_W too small for NCH words");
   end
   if (EN_BIT >= DATA_W) begin : g_bad_en
      $error("twin_pwm: EN_BIT outside the word");
   end
   if (DUTY_LSB + CW > RELOAD_LSB) begin : g_bad_duty
      $error("twin_pwm: level field overlaps divider field");
   end
   if (RELOAD_LSB + CW > EN_BIT) begin : g_bad_reload
      $error("twin_pwm: divider field overlaps run flag");
   end

   logic [NCH-1:0][DATA_W-1:0] ctl_q;
   logic [NCH-1:0][CW-1:0]     ph_q;
   logic [NCH-1:0][CW-1:0]     pc_q;
   logic [NCH-1:0][CW-1:0]     sh_duty;
   logic [NCH-1:0]             act_q;

   twin_pwm_regs #(
      .NCH    (NCH),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ctl_q     (ctl_q)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      twin_pwm_chan #(.CW(CW)) chan_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .en_i      (ctl_q[c][EN_BIT]),
         .reload_i  (ctl_q[c][RELOAD_LSB +: CW]),
         .duty_i    (ctl_q[c][DUTY_LSB +: CW]),
         .pwm_o     (pwm_out[c]),
         .phase_o   (ph_q[c]),
         .presc_o   (pc_q[c]),
         .run_o     (act_q[c]),
         .duty_sh_o (sh_duty[c])
      );
   end

endmodule

// File: rtl/twin_pwm_chk.sv
module twin_pwm_chk
   import twin_pwm_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int CW     = 8,
   parameter int EN_BIT = 31
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic                       bus_wr,
   input logic [DATA_W-1:0]          bus_wdata,
   input logic [NCH-1:0][DATA_W-1:0] ctl_q,
   input logic [NCH-1:0]             pwm_out,
   input logic [NCH-1:0][CW-1:0]     ph_q,
   input logic [NCH-1:0][CW-1:0]     pc_q,
   input logic [NCH-1:0]             act_q,
   input logic [NCH-1:0][CW-1:0]     sh_duty
);

   logic [ADDR_W-WORD_SHIFT-1:0] idx;
   logic                         hit;

   assign idx = bus_addr[ADDR_W-1:WORD_SHIFT];
   assign hit = (bus_addr[WORD_SHIFT-1:0] == '0) && (int'(idx) < NCH);

   // R3: undecoded writes leave every word alone
   assert_ignored_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit) |=> $stable(ctl_q));

   for (genvar c = 0; c < NCH; c++) begin : g_c
      // R2: decoded write stores the whole data word
      assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && hit && int'(idx) == c) |=> (ctl_q[c] == $past(bus_wdata)));

      // R4: a write that clears the run flag silences the pin
      assert_stop_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && hit && int'(idx) == c && !bus_wdata[EN_BIT]) |=> !pwm_out[c]);

      // R7: level code 0 never drives high
      assert_code0_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (act_q[c] && sh_duty[c] == '0) |-> !pwm_out[c]);

      // R9: a start begins at phase 0 with a cleared divider
      assert_start_phase0_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(act_q[c]) |-> (ph_q[c] == '0 && pc_q[c] == '0));

      // R10: level shadow only moves at a period boundary or while stopped
      assert_boundary_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(sh_duty[c]) |-> ((ph_q[c] == '0 && pc_q[c] == '0) || !$past(act_q[c])));
   end

endmodule

bind twin_pwm twin_pwm_chk #(
   .NCH    (NCH),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .CW     (CW),
   .EN_BIT (EN_BIT)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .ctl_q     (ctl_q),
   .pwm_out   (pwm_out),
   .ph_q      (ph_q),
   .pc_q      (pc_q),
   .act_q     (act_q),
   .sh_duty   (sh_duty)
);

// File: tb/twin_pwm_tb_top.sv
`timescale 1ns/1ps
module twin_pwm_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  pwm_out;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   twin_pwm dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   // {channel, divider, level}
   localparam logic [23:0] VEC_TAB [0:7] = '{
      24'h00_01_80, 24'h00_01_01, 24'h00_01_FF, 24'h00_01_00,
      24'h01_03_C8, 24'h01_02_40, 24'h00_00_C0, 24'h01_FF_FA
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // sample n cycles at negedges, optionally issuing one write after sample 'mid'
   task automatic run_win(input int n, input int mid, input logic [3:0] ma,
                          input logic [31:0] md, output int h0, output int h1,
                          output logic f0, output logic f1);
      h0 = 0; h1 = 0; f0 = 1'b0; f1 = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == 0) begin
            f0 = pwm_out[0];
            f1 = pwm_out[1];
         end
         h0 += int'(pwm_out[0]);
         h1 += int'(pwm_out[1]);
         if (i == mid) begin
            bus_addr  = ma;
            bus_wdata = md;
            bus_wr    = 1'b1;
         end else begin
            bus_wr = 1'b0;
         end
      end
      bus_wr = 1'b0;
   endtask

   initial begin : watchdog
      repeat (195000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      int h0, h1;
      logic f0, f1;

      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      bus_read(4'h0, rd); check("R1 word0", rd, 32'h0);
      bus_read(4'h4, rd); check("R1 word1", rd, 32'h0);
      check("R1 outputs", {30'h0, pwm_out}, 32'h0);

      // R2 + R4: full-word read-back with run flag clear keeps the pin low
      bus_write(4'h4, 32'h7ABC_1234);
      bus_read(4'h4, rd); check("R2 word1 readback", rd, 32'h7ABC_1234);
      run_win(300, -1, 4'h0, 32'h0, h0, h1, f0, f1);
      check("R4 stopped ch1 low", h1, 0);

      // R3: undecoded offsets ignored and read as 0
      bus_write(4'h0, 32'h0055_AA00);
      bus_write(4'h8, 32'hFFFF_FFFF);
      bus_write(4'hC, 32'h8000_0101);
      bus_write(4'h5, 32'h8000_0101);
      bus_write(4'h2, 32'h8000_0101);
      bus_read(4'h0, rd); check("R3 word0 untouched", rd, 32'h0055_AA00);
      bus_read(4'h4, rd); check("R3 word1 untouched", rd, 32'h7ABC_1234);
      bus_read(4'h8, rd); check("R3 read offset 8", rd, 32'h0);
      bus_read(4'hC, rd); check("R3 read offset 12", rd, 32'h0);
      bus_read(4'h1, rd); check("R3 read offset 1", rd, 32'h0);
      check("R3 pins low", {30'h0, pwm_out}, 32'h0);
      bus_write(4'h4, 32'h0);

      // vector table: R5 R6 R7 R8 R9 R11
      for (int v = 0; v < 8; v++) begin
         int ch, dv, lv, per, exp_hi;
         logic [31:0] word;
         string tag;
         ch  = int'(VEC_TAB[v][23:16]);
         dv  = int'(VEC_TAB[v][15:8]);
         lv  = int'(VEC_TAB[v][7:0]);
         per = (dv == 0) ? 256 : dv;
         exp_hi = (lv == 0) ? 0 : (256 - lv) * per;
         if (dv == 0) tag = "R6";
         else if (lv == 0) tag = "R7";
         else if (lv == 1 || lv == 255) tag = "R8";
         else tag = "R5";
         word = 32'h8000_0000 | (32'(dv) << 8) | 32'(lv);
         bus_write(4'(ch * 4), word);
         @(posedge clk);
         run_win(256 * per, -1, 4'h0, 32'h0, h0, h1, f0, f1);
         check({tag, " high cycles"}, (ch == 0) ? h0 : h1, exp_hi);
         check("R9 high at phase 0", {31'h0, (ch == 0) ? f0 : f1}, {31'h0, lv != 0});
         check("R11 idle channel low", (ch == 0) ? h1 : h0, 0);
         bus_read(4'(ch * 4), rd); check("R2 readback", rd, word);
         bus_write(4'(ch * 4), word & 32'h7FFF_FFFF);
         @(negedge clk);
         check("R4 low after stop", {31'h0, pwm_out[ch]}, 32'h0);
      end

      // R10: mid-period update waits for the boundary
      bus_write(4'h0, 32'h8000_0180);
      @(posedge clk);
      run_win(256, 40, 4'h0, 32'h8000_0140, h0, h1, f0, f1);
      check("R10 old period intact", h0, 128);
      run_win(256, -1, 4'h0, 32'h0, h0, h1, f0, f1);
      check("R10 new period", h0, 192);
      bus_write(4'h0, 32'h0);

      // R11: both channels at once with different settings
      bus_write(4'h0, 32'h8000_01C0);
      bus_write(4'h4, 32'h8000_0120);
      @(posedge clk);
      run_win(256, -1, 4'h0, 32'h0, h0, h1, f0, f1);
      check("R11 ch0 concurrent", h0, 64);
      check("R11 ch1 concurrent", h1, 224);
      bus_write(4'h4, 32'h0000_0120);
      run_win(256, -1, 4'h0, 32'h0, h0, h1, f0, f1);
      check("R11 ch0 unaffected by ch1 stop", h0, 64);
      check("R4 ch1 stopped", h1, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule